// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Forwarding

This block sits between a write-through cache and the next memory level. The processor hands it stores, each an address with a word of data. Each store is accepted in one cycle whenever an entry is free, so memory write latency never holds the processor up. The buffer sends the held stores to memory one at a time, oldest first, over a valid/ready write channel. A burst of stores fills several entries rather than stalling behind a single register.

Processor reads also pass through the block, one at a time. A read is compared against every held store. If any entry has the same address, the youngest such entry answers the read on the next cycle, and memory is not asked. If no entry matches, the read goes out on a separate valid/ready read channel. Reads take priority over draining: no new store is offered to memory while a read is waiting or in progress. A store already offered to memory stays offered until it is taken. Because a missing read cannot share an address with a held store, letting it pass the older stores is safe.

Back-pressure rules. Every channel follows valid/ready. A transfer happens on a rising edge where both are high. Once valid is raised, the sender holds valid and the payload until ready. The store channel drops `st_ready` (the processor stall) only while all entries are full. The read channel drops `rd_ready` while a read is in progress. The two response inputs and outputs are single-cycle pulses without ready. `DEPTH` must be a power of two and at least 2.

Top module: `wb_write_buffer`

## Requirements
- R1: After reset, `st_ready` and `rd_ready` are 1, and `mw_valid`, `mr_valid` and `rd_rsp_valid` are 0.
- R2: A store is accepted (`st_ready`=1) whenever fewer than `DEPTH` entries are held. With `DEPTH` entries held, `st_ready` is 0 (stall) until an entry drains.
- R3: Entries go to memory strictly in acceptance order, one per `mw_valid`&`mw_ready` cycle. While `mw_ready` is 0, `mw_valid`, `mw_addr` and `mw_data` stay unchanged. Every accepted store eventually reaches memory.
- R4: A read whose address equals that of a held entry is answered from the youngest matching entry, with `rd_rsp_valid` high exactly one cycle after the read is accepted, and no memory read is issued.
- R5: A read that matches no held entry raises `mr_valid` with `mr_addr` equal to the read address on the cycle after acceptance. `rd_rsp_valid` then rises one cycle after `mr_rsp_valid`, carrying `mr_rsp_data`.
- R6: No new store is offered to memory (`mw_valid` rising, or a new entry offered after a transfer) in a cycle where `rd_valid` is high or a read is in progress. A miss read completes while older stores remain held.
- R7: Every read returns the value that results from applying all stores accepted before it, in acceptance order (unwritten words read as memory holds them). A store accepted in the same cycle as a read counts as later.
- R8: While `mr_ready` is 0, `mr_valid` and `mr_addr` stay unchanged, and the address sent is that of the current read.
- R9: `rd_ready` is 0 from the cycle after a read is accepted until its response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store offered |
| st_ready | output | 1 | Store accepted this cycle; low means stall |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Processor read request |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_addr | input | AW | Read address |
| rd_rsp_valid | output | 1 | Read response pulse |
| rd_rsp_data | output | DW | Read response data |
| mw_valid | output | 1 | Memory write offered |
| mw_ready | input | 1 | Memory takes the write |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mr_valid | output | 1 | Memory read request |
| mr_ready | input | 1 | Memory takes the read request |
| mr_addr | output | AW | Memory read address |
| mr_rsp_valid | input | 1 | Memory read data pulse |
| mr_rsp_data | input | DW | Memory read data |

## Verification
The assertions assume the following about the block's inputs. The processor issues a store or a read only as a valid/ready offer that it holds until accepted. Memory sends exactly one `mr_rsp_valid` pulse per accepted read request, and never before the request. The bench respects both. Its processor model is a single thread that holds each offer and waits for every read response before its next operation. Its memory model queues one response per accepted request, after a random delay of zero to two cycles. Ready inputs on both memory channels are randomised or forced low to build full-buffer and held-drain cases.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    RD_IDLE,
    RD_MREQ,
    RD_MWAIT,
    RD_RESP
  } rd_state_e;
endpackage

// File: rtl/wb_entry_fifo.sv
module wb_entry_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic                       full,
  output logic                       empty,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [DEPTH-1:0]           slot_vld,
  output logic [DEPTH-1:0][AW-1:0]   slot_addr,
  output logic [DEPTH-1:0][DW-1:0]   slot_data,
  output logic [PW-1:0]              tail_ptr
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0]         vld_q;
  logic [PW-1:0]            head_q, tail_q;

  // pointers wrap naturally: DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + PW'(1);
      if (pop)  head_q <= head_q + PW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (push && tail_q == PW'(g)) begin
        vld_q[g] <= 1'b1;
      end else if (pop && head_q == PW'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (push && tail_q == PW'(g)) begin
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
      end
    end
  end

  assign full      = &vld_q;
  assign empty     = ~|vld_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign slot_vld  = vld_q;
  assign slot_addr = addr_q;
  assign slot_data = data_q;
  assign tail_ptr  = tail_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R3
  head_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (head_q == $past(head_q) + PW'(1)));
endmodule

// File: rtl/wb_fwd_match.sv
module wb_fwd_match #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           slot_vld,
  input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]   slot_data,
  input  logic [PW-1:0]              tail_ptr,
  input  logic [AW-1:0]              look_addr,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  // order 0 is the most recently written slot, order DEPTH-1 the oldest
  logic [DEPTH-1:0][PW-1:0] ord_idx;
  logic [DEPTH-1:0]         ord_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ord
    assign ord_idx[g] = tail_ptr - PW'(g + 1);
    assign ord_hit[g] = slot_vld[ord_idx[g]] && (slot_addr[ord_idx[g]] == look_addr);
  end

  always_comb begin
    hit      = |ord_hit;
    hit_data = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (ord_hit[k]) hit_data = slot_data[ord_idx[k]];
    end
  end
endmodule

// File: rtl/wb_read_ctrl.sv
module wb_read_ctrl
  import wb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic          mr_rsp_valid,
  input  logic [DW-1:0] mr_rsp_data,
  output logic          busy
);
  rd_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        RD_IDLE: if (rd_valid) begin
          addr_q <= rd_addr;
          if (hit) begin
            data_q <= hit_data;
            st_q   <= RD_RESP;
          end else begin
            st_q   <= RD_MREQ;
          end
        end
        RD_MREQ:  if (mr_ready) st_q <= RD_MWAIT;
        RD_MWAIT: if (mr_rsp_valid) begin
          data_q <= mr_rsp_data;
          st_q   <= RD_RESP;
        end
        RD_RESP:  st_q <= RD_IDLE;
        default:  st_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_ready     = (st_q == RD_IDLE);
  assign mr_valid     = (st_q == RD_MREQ);
  assign mr_addr      = addr_q;
  assign rd_rsp_valid = (st_q == RD_RESP);
  assign rd_rsp_data  = data_q;
  assign busy         = (st_q != RD_IDLE);

  // R4
  fwd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && hit) |=> (rd_rsp_valid && rd_rsp_data == $past(hit_data) && !mr_valid));
  // R5
  miss_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !hit) |=> (mr_valid && mr_addr == $past(rd_addr)));
  // R5
  miss_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mr_valid && mr_rsp_valid) |=> (rd_rsp_valid && rd_rsp_data == $past(mr_rsp_data)));
  // R8
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && !mr_ready) |=> (mr_valid && $stable(mr_addr)));
endmodule

// File: rtl/wb_write_buffer.sv
module wb_write_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic          mr_rsp_valid,
  input  logic [DW-1:0] mr_rsp_data
);
  localparam int PW = $clog2(DEPTH);

  logic                     full, empty, push, pop;
  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [PW-1:0]            tail_ptr;
  logic                     hit, rd_busy, drain_held_q;
  logic [DW-1:0]            hit_data;

  assign st_ready = !full;
  assign push     = st_valid && st_ready;
  assign pop      = mw_valid && mw_ready;

  // a held offer must complete; a new one waits for the read side to be quiet
  assign mw_valid = !empty && (drain_held_q || (!rd_busy && !rd_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) drain_held_q <= 1'b0;
    else        drain_held_q <= mw_valid && !mw_ready;
  end

  wb_entry_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .full(full), .empty(empty),
    .head_addr(mw_addr), .head_data(mw_data),
    .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data),
    .tail_ptr(tail_ptr)
  );

  wb_fwd_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data),
    .tail_ptr(tail_ptr), .look_addr(rd_addr),
    .hit(hit), .hit_data(hit_data)
  );

  wb_read_ctrl #(.AW(AW), .DW(DW)) u_rdctl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .hit(hit), .hit_data(hit_data),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mr_rsp_valid(mr_rsp_valid), .mr_rsp_data(mr_rsp_data),
    .busy(rd_busy)
  );

  // R3
  mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
  // R6
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !$past(mw_valid && !mw_ready)) |-> (!rd_valid && rd_ready));
  // R2
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ready && mw_valid && mw_ready) |=> st_ready);
endmodule

// File: tb/wb_write_buffer_bench.sv
module wb_write_buffer_bench;
  localparam int AW = 16, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_ready, rd_valid = 0, rd_ready, rd_rsp_valid;
  logic [AW-1:0] st_addr = '0, rd_addr = '0, mw_addr, mr_addr;
  logic [DW-1:0] st_data = '0, rd_rsp_data, mw_data, mr_rsp_data = '0;
  logic mw_valid, mw_ready = 0, mr_valid, mr_ready = 0, mr_rsp_valid = 0;

  wb_write_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_wb_write_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mr_rsp_valid(mr_rsp_valid), .mr_rsp_data(mr_rsp_data)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, acc_cyc = 0, mw_mode = 0;
  logic [DW-1:0] ref_prog [256];
  logic [DW-1:0] mem [256];
  logic [AW-1:0] q_a [64];
  logic [DW-1:0] q_d [64];
  int q_head = 0, q_tail = 0, q_cnt = 0;
  bit st_acc, rd_acc, rd_wait, rd_was_miss, prev_mw_hold, prev_mrrsp, rsp_pend;
  int rsp_cnt = 0;
  logic [DW-1:0] rsp_data, exp_rd, last_rsp;
  logic [AW-1:0] rd_addr_cur;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit in_queue(input logic [AW-1:0] a);
    for (int i = 0; i < q_cnt; i++)
      if (q_a[(q_head + i) % 64] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic begin_cycle();
    @(posedge clk);
    #2;
    cyc++;
    st_valid = 0;
    rd_valid = 0;
    mr_rsp_valid = 0;
    mw_ready = (mw_mode == 0) ? 1'($urandom % 2) : (mw_mode == 2);
    mr_ready = 1'($urandom % 2);
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mr_rsp_valid = 1;
        mr_rsp_data  = rsp_data;
      end else rsp_cnt--;
    end
  endtask

  task automatic end_cycle();
    #3;
    st_acc = 0;
    rd_acc = 0;
    if (st_valid) chk(st_ready == (q_cnt < DEPTH), "R2 st_ready", st_ready, q_cnt < DEPTH);
    if (st_valid && st_ready) begin
      ref_prog[st_addr[7:0]] = st_data;
      q_a[q_tail] = st_addr; q_d[q_tail] = st_data;
      q_tail = (q_tail + 1) % 64; q_cnt++;
      st_acc = 1;
    end
    if (mw_valid && !prev_mw_hold)
      chk(!rd_valid && !rd_wait, "R6 new drain during read", {rd_valid, rd_wait}, 0);
    if (mw_valid && mw_ready) begin
      chk(q_cnt > 0 && mw_addr == q_a[q_head] && mw_data == q_d[q_head],
          "R3 drain order", {mw_addr, mw_data}, {q_a[q_head], q_d[q_head]});
      mem[mw_addr[7:0]] = mw_data;
      q_head = (q_head + 1) % 64; q_cnt--;
    end
    prev_mw_hold = mw_valid && !mw_ready;
    if (mr_valid && mr_ready) begin
      chk(mr_addr == rd_addr_cur, "R8 mr_addr", mr_addr, rd_addr_cur);
      chk(!in_queue(mr_addr), "R4 buffered address sent to memory", mr_addr, 0);
      rsp_pend = 1; rsp_cnt = $urandom % 3; rsp_data = mem[mr_addr[7:0]];
      rd_was_miss = 1;
    end
    if (rd_valid && rd_ready) begin
      exp_rd = ref_prog[rd_addr[7:0]];
      rd_wait = 1; rd_acc = 1; rd_addr_cur = rd_addr; rd_was_miss = 0; acc_cyc = cyc;
    end
    if (rd_rsp_valid) begin
      chk(rd_wait, "R7 unexpected response", rd_rsp_valid, rd_wait);
      chk(rd_rsp_data == exp_rd, "R7 read data", rd_rsp_data, exp_rd);
      if (rd_was_miss) chk(prev_mrrsp, "R5 response timing", prev_mrrsp, 1);
      else chk(cyc == acc_cyc + 1, "R4 forward latency", cyc - acc_cyc, 1);
      last_rsp = rd_rsp_data;
      rd_wait = 0;
    end
    prev_mrrsp = mr_rsp_valid;
    if (mr_rsp_valid) rsp_pend = 0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do begin
      begin_cycle();
      st_valid = 1; st_addr = a; st_data = d;
      end_cycle();
    end while (!st_acc);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    bit first;
    do begin
      begin_cycle();
      rd_valid = 1; rd_addr = a;
      end_cycle();
    end while (!rd_acc);
    first = 1;
    while (rd_wait) begin
      begin_cycle();
      end_cycle();
      if (first && rd_wait) chk(!rd_ready, "R9 rd_ready during read", rd_ready, 0);
      first = 0;
    end
  endtask

  task automatic idle_until_empty();
    mw_mode = 2;
    while (q_cnt != 0) begin begin_cycle(); end_cycle(); end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin ref_prog[i] = '0; mem[i] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    chk(st_ready && rd_ready, "R1 ready after reset", {st_ready, rd_ready}, 2'b11);
    chk(!mw_valid && !mr_valid && !rd_rsp_valid, "R1 valids after reset",
        {mw_valid, mr_valid, rd_rsp_valid}, 0);

    // R2: fill with memory blocked, then stall
    mw_mode = 1;
    for (int i = 1; i <= DEPTH; i++) do_store(AW'(i), DW'(32'h100 + i));
    for (int i = 0; i < 3; i++) begin
      begin_cycle();
      st_valid = 1; st_addr = 16'h5; st_data = 32'h105;
      end_cycle();
      chk(!st_ready, "R2 stall when full", st_ready, 0);
      chk(mw_valid && mw_addr == 16'h1, "R3 oldest held offered", mw_addr, 1);
    end
    mw_mode = 2;
    do_store(16'h5, 32'h105);
    idle_until_empty();

    // R4: youngest matching entry forwards
    mw_mode = 1;
    do_store(16'h7, 32'hA1);
    do_store(16'h9, 32'hB2);
    do_store(16'h7, 32'hC3);
    do_read(16'h7);
    chk(last_rsp == 32'hC3, "R4 youngest forward", last_rsp, 32'hC3);

    // R6: miss read completes while older stores stay held
    do_read(16'h3);
    chk(last_rsp == mem[3], "R5 miss data", last_rsp, mem[3]);
    chk(q_cnt == 3, "R6 read passed held stores", q_cnt, 3);
    idle_until_empty();
    do_read(16'h9);
    chk(last_rsp == 32'hB2, "R7 read after drain", last_rsp, 32'hB2);

    // random mix
    mw_mode = 0;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 55) do_store(AW'($urandom % 12), $urandom);
      else if (r < 90) do_read(AW'($urandom % 12));
      else begin begin_cycle(); end_cycle(); end
    end

    // R3 every store reaches memory
    idle_until_empty();
    for (int i = 0; i < 16; i++)
      chk(mem[i] == ref_prog[i], "R3 final memory", mem[i], ref_prog[i]);
    summary();
    $finish;
  end
endmodule